// File: doc/BRIEF.md
# Access-Triggered CPU Clock Downshifter

This block chooses the clock-enable rate that paces a Z80-style CPU. By default the CPU runs at a fast rate, about 7.16 MHz, which is the master clock divided by `FAST_DIV`. When the CPU performs an I/O read or write to the video display processor's port group, the block drops to the standard 3.58 MHz rate, which is the master clock divided by `SLOW_DIV`. It holds that rate for a programmable number of master-clock cycles. Each further video access restarts the hold window. When the window runs out, the fast rate comes back. No software is involved.

A rate change takes effect only on a cycle where `cpu_ce` is high. No CPU clock period is ever cut short. The hold length comes from the `hold_cycles` input and is counted in master-clock cycles. A hold length of zero turns downshifting off completely.

Top module: `cpu_clk_downshift`

## Requirements
- R1: While reset is active, `slow_mode` is 1, `cpu_ce` is 0 and the hold counter is cleared. With no video access after reset, the first `cpu_ce` comes `SLOW_DIV` cycles after release, and fast mode starts from that pulse.
- R2: While `slow_mode` is 0, `cpu_ce` is high for one master cycle in every `FAST_DIV` cycles (default 4).
- R3: While `slow_mode` is 1, `cpu_ce` is high for one master cycle in every `SLOW_DIV` cycles (default 8).
- R4: A video access is a cycle with `iorq_n`=0, at least one of `rd_n` or `wr_n` at 0, and `io_addr_lo[7:2]`=6'b100110, which covers ports 98h to 9Bh. Reads and writes both count.
- R5: The following do not trigger anything: I/O cycles to any other port, cycles with `iorq_n`=1 (memory cycles), and cycles with `iorq_n`=0 where both strobes are high.
- R6: Take a video access seen at rising edge t, with a nonzero hold length H. From edge t+1 the hold counter holds H and then counts down by one per cycle. Slow mode is requested while the counter is nonzero.
- R7: A video access while the counter is running reloads it to the full value of H.
- R8: When `hold_cycles` is 0, the counter is forced to 0 and a video access has no effect. The rate stays fast.
- R9: `slow_mode` changes only on the cycle after a `cpu_ce` pulse. The gap between `cpu_ce` pulses is always exactly `FAST_DIV` or `SLOW_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_addr_lo | input | 8 | Low byte of the CPU address bus |
| hold_cycles | input | HOLD_W | Hold window in master cycles; 0 turns downshifting off |
| cpu_ce | output | 1 | CPU clock enable, one master cycle wide |
| slow_mode | output | 1 | 1 while the slow rate is in force |

## Verification
The bench drives a write burst and a read burst to the decoded ports 98h and 9Bh. These show whether both strobe kinds and both ends of the port range are decoded. It also drives near misses: ports 97h and 9Ch, a memory cycle at 98h, and an I/O request with neither strobe low. These must leave the rate unchanged, which shows the decode is not too wide.

Repeated accesses spaced closer than the hold window must keep the slow rate in force throughout. This distinguishes a reload from a single load. A run with the hold set to zero shows that the disable works. A behavioural model compares both outputs on every cycle, so any error in the timing of a rate change at a clock-enable boundary shows up as a miscompare.

// File: rtl/cpu_clk_downshift_pkg.sv
package cpu_clk_downshift_pkg;

    // Port group of the video display processor: upper six bits of the low address byte
    localparam logic [7:0] VDP_PORT_BASE = 8'h98;
    localparam int         VDP_PORT_SPAN_BITS = 2;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

endpackage

// File: rtl/vdp_port_decode.sv
module vdp_port_decode
    import cpu_clk_downshift_pkg::*;
#(
    parameter logic [7:0] PORT_BASE = VDP_PORT_BASE,
    parameter int         SPAN_BITS = VDP_PORT_SPAN_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iorq_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] io_addr_lo,
    output logic       hit_o
);

    localparam int TAG_W = 8 - SPAN_BITS;
    localparam logic [TAG_W-1:0] PORT_TAG = PORT_BASE[7:SPAN_BITS];

    typedef struct packed {
        logic hit;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       io_cycle;
    logic       tag_match;

    always_comb begin
        io_cycle  = !iorq_n && (!rd_n || !wr_n);
        tag_match = (io_addr_lo[7:SPAN_BITS] == PORT_TAG);
        st_d      = st_q;
        st_d.hit  = io_cycle && tag_match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = st_q.hit;

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              busy_o
);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       disabled;
    logic       running;

    always_comb begin
        disabled = (hold_cycles == '0);
        running  = (st_q.cnt != '0);
        st_d     = st_q;
        if (disabled) begin
            st_d.cnt = '0;
        end else if (trig_i) begin
            st_d.cnt = hold_cycles;
        end else if (running) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.cnt != '0);

endmodule

// File: rtl/ce_rate_gen.sv
module ce_rate_gen
    import cpu_clk_downshift_pkg::*;
#(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_slow_i,
    output logic ce_o,
    output logic slow_o
);

    localparam int DIV_W = (SLOW_DIV > FAST_DIV) ? $clog2(SLOW_DIV) : $clog2(FAST_DIV);
    localparam logic [DIV_W-1:0] FAST_LAST = DIV_W'(FAST_DIV - 1);
    localparam logic [DIV_W-1:0] SLOW_LAST = DIV_W'(SLOW_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        rate_e            rate;
    } gen_state_t;

    gen_state_t       st_d, st_q;
    logic [DIV_W-1:0] last;
    logic             boundary;

    always_comb begin
        last     = (st_q.rate == RATE_SLOW) ? SLOW_LAST : FAST_LAST;
        boundary = (st_q.div == last);
        st_d     = st_q;
        if (boundary) begin
            st_d.div  = '0;
            st_d.rate = want_slow_i ? RATE_SLOW : RATE_FAST;
        end else begin
            st_d.div  = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div  <= '0;
            st_q.rate <= RATE_SLOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign ce_o   = boundary;
    assign slow_o = (st_q.rate == RATE_SLOW);

endmodule

// File: rtl/cpu_clk_downshift.sv
module cpu_clk_downshift
    import cpu_clk_downshift_pkg::*;
#(
    parameter int HOLD_W   = 16,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [7:0]        io_addr_lo,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              cpu_ce,
    output logic              slow_mode
);

    logic vdp_hit;
    logic hold_busy;

    vdp_port_decode #(
        .PORT_BASE (VDP_PORT_BASE),
        .SPAN_BITS (VDP_PORT_SPAN_BITS)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .iorq_n     (iorq_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .io_addr_lo (io_addr_lo),
        .hit_o      (vdp_hit)
    );

    hold_timer #(
        .HOLD_W (HOLD_W)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (vdp_hit),
        .hold_cycles (hold_cycles),
        .busy_o      (hold_busy)
    );

    ce_rate_gen #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_rate (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_slow_i (hold_busy),
        .ce_o        (cpu_ce),
        .slow_o      (slow_mode)
    );

endmodule

// File: rtl/cpu_clk_downshift_chk.sv
module cpu_clk_downshift_chk #(
    parameter int HOLD_W   = 16,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HOLD_W-1:0] hold_cycles,
    input logic              cpu_ce,
    input logic              slow_mode
);

    localparam int GAP_W = $clog2(SLOW_DIV + FAST_DIV) + 1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (cpu_ce) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_RESET_SLOW: assert property (@(posedge clk)
        !rst_n |=> (slow_mode && !cpu_ce)); // R1

    AST_FAST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && !slow_mode) |-> (gap_q == GAP_W'(FAST_DIV - 1))); // R2

    AST_SLOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && slow_mode) |-> (gap_q == GAP_W'(SLOW_DIV - 1))); // R3

    AST_ZERO_HOLD_STAYS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_mode && hold_cycles == '0 && $past(hold_cycles) == '0) |=> !slow_mode); // R8

    AST_SWITCH_AT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slow_mode) |-> $past(cpu_ce)); // R9

endmodule

bind cpu_clk_downshift cpu_clk_downshift_chk #(
    .HOLD_W   (HOLD_W),
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_cycles (hold_cycles),
    .cpu_ce      (cpu_ce),
    .slow_mode   (slow_mode)
);

// File: tb/cpu_clk_downshift_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_downshift_tb_top;

    localparam int HOLD_W   = 16;
    localparam int FAST_DIV = 4;
    localparam int SLOW_DIV = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iorq_n = 1'b1;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [7:0]        io_addr_lo = 8'h00;
    logic [HOLD_W-1:0] hold_cycles = '0;
    logic              cpu_ce;
    logic              slow_mode;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    finished = 1'b0;

    // reference model state
    int m_phase = 0;
    int m_slow = 1;
    int m_remain = 0;
    int m_hit_prev = 0;

    always #2.5 clk = ~clk;

    cpu_clk_downshift #(
        .HOLD_W   (HOLD_W),
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .iorq_n      (iorq_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .io_addr_lo  (io_addr_lo),
        .hold_cycles (hold_cycles),
        .cpu_ce      (cpu_ce),
        .slow_mode   (slow_mode)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_slow = 1; m_remain = 0; m_hit_prev = 0;
        end else begin
            int period;
            int next_remain;
            int hit_now;
            period  = (m_slow != 0) ? SLOW_DIV : FAST_DIV;
            hit_now = (!iorq_n && (!rd_n || !wr_n) &&
                       io_addr_lo >= 8'h98 && io_addr_lo <= 8'h9B) ? 1 : 0;
            if (hold_cycles == 0)      next_remain = 0;
            else if (m_hit_prev != 0)  next_remain = int'(hold_cycles);
            else if (m_remain > 0)     next_remain = m_remain - 1;
            else                       next_remain = 0;
            if (m_phase == period - 1) begin
                m_slow  = (m_remain != 0) ? 1 : 0;
                m_phase = 0;
            end else begin
                m_phase = m_phase + 1;
            end
            m_remain   = next_remain;
            m_hit_prev = hit_now;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            int exp_ce;
            exp_ce = (m_phase == ((m_slow != 0) ? SLOW_DIV : FAST_DIV) - 1) ? 1 : 0;
            check(int'(cpu_ce) == exp_ce, {cur_tag, " cpu_ce"}, int'(cpu_ce), exp_ce);
            check(int'(slow_mode) == m_slow, {cur_tag, " slow_mode"}, int'(slow_mode), m_slow);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus(input logic [7:0] a, input bit iorq, input bit rd, input bit wr, input int len);
        @(negedge clk);
        io_addr_lo = a; iorq_n = ~iorq; rd_n = ~rd; wr_n = ~wr;
        idle(len);
        iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; io_addr_lo = 8'h00;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then released with no access
        cur_tag = "R1";
        idle(4);
        check(slow_mode == 1'b1, "R1 slow during reset", int'(slow_mode), 1);
        check(cpu_ce == 1'b0, "R1 no ce during reset", int'(cpu_ce), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(20);
        check(slow_mode == 1'b0, "R1 fast after idle release", int'(slow_mode), 0);
        // R2: fast rate steady
        cur_tag = "R2";
        idle(24);
        // R4: write burst to 98h, hold 50
        cur_tag = "R4";
        hold_cycles = 16'd50;
        bus(8'h98, 1'b1, 1'b0, 1'b1, 2);
        idle(4);
        check(slow_mode == 1'b1, "R4 write to 98h downshifts", int'(slow_mode), 1);
        // R3/R6: slow period, then expiry
        cur_tag = "R3";
        idle(30);
        cur_tag = "R6";
        idle(50);
        check(slow_mode == 1'b0, "R6 fast after hold expiry", int'(slow_mode), 0);
        // R4: read of 9Bh
        cur_tag = "R4";
        bus(8'h9B, 1'b1, 1'b1, 1'b0, 3);
        idle(70);
        // R5: near misses and non-I/O cycles
        cur_tag = "R5";
        bus(8'h97, 1'b1, 1'b0, 1'b1, 3);
        bus(8'h9C, 1'b1, 1'b1, 1'b0, 3);
        bus(8'h98, 1'b0, 1'b1, 1'b0, 3);
        bus(8'h99, 1'b1, 1'b0, 1'b0, 3);
        idle(12);
        check(slow_mode == 1'b0, "R5 ignored cycles keep fast", int'(slow_mode), 0);
        // R7: retrigger every 40 cycles with hold 60
        cur_tag = "R7";
        hold_cycles = 16'd60;
        for (int k = 0; k < 5; k++) begin
            bus(8'h9A, 1'b1, 1'b0, 1'b1, 1);
            idle(39);
            check(slow_mode == 1'b1, "R7 reload keeps slow", int'(slow_mode), 1);
        end
        idle(80);
        check(slow_mode == 1'b0, "R7 fast after final window", int'(slow_mode), 0);
        // R8: zero hold disables, also cuts a running window
        cur_tag = "R8";
        hold_cycles = 16'd0;
        bus(8'h98, 1'b1, 1'b0, 1'b1, 2);
        idle(30);
        check(slow_mode == 1'b0, "R8 zero hold stays fast", int'(slow_mode), 0);
        hold_cycles = 16'd200;
        bus(8'h99, 1'b1, 1'b1, 1'b0, 1);
        idle(20);
        hold_cycles = 16'd0;
        idle(30);
        check(slow_mode == 1'b0, "R8 clearing hold ends window", int'(slow_mode), 0);
        // R9: mid-period accesses with odd offsets, boundary alignment checked per cycle
        cur_tag = "R9";
        hold_cycles = 16'd13;
        for (int k = 0; k < 6; k++) begin
            idle(k + 1);
            bus(8'h98, 1'b1, 1'b0, 1'b1, 1);
            idle(25);
        end
        idle(10);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule